// File: doc/BRIEF.md
# Timer Capture/Compare Channel Bank

Eight timer channels share one free-running counter. Each channel is set by software to either input capture or output compare. In capture mode the channel watches its input pin through a synchronizer. On the edge kind selected for it, the channel copies the counter into its data register and raises its flag. In compare mode the channel watches for the counter to arrive at the value in its data register. When it does, the channel raises its flag and updates its output level with a selected action: toggle, clear, set, or leave it alone.

Software reaches every setting through a small word-wide register port with a combinational read path. Per-channel edge codes and action codes are packed four channels to a register, with the highest channel in the top bit pair. A pin-drive vector tells the pad logic which channels currently own their pins. Two release outputs tell an external pulse accumulator when it may take over the pins of channel 7 or channel 0.

Top module: `tmr_chan_bank`

## Requirements
- R1: After reset the counter, every data register, every control register and every flag are 0. cmp_out is 0, pin_drive is all ones and pa_release is 0.
- R2: The counter adds one at each clock edge where tick is high, holds its value when tick is low, and wraps from 0xFFFF to 0x0000.
- R3: Register map, all readable and writable at any time, with control values in the low 8 bits. The map is: 0 = edge codes of ch7..ch4, 1 = edge codes of ch3..ch0, 2 = action codes of ch7..ch4, 3 = action codes of ch3..ch0. Within these four registers, channel n uses bits [2(n mod 4)+1 : 2(n mod 4)]. The remaining addresses are: 4 = mode (bit n set means ch n is capture), 5 = flags, 6 = release mask (only bits 7 and 0 are stored, the others read 0), 7 = counter (reads give the count, writes are ignored), 8+n = data register of ch n.
- R4: Edge code 00 disables capture, 01 captures rising edges, 10 captures falling edges and 11 captures both. A qualifying edge on a capture channel loads the counter into the data register and sets the flag.
- R5: A pin change that is held is captured at the third rising clock edge after it, never earlier. The value stored is the counter value present just before that edge.
- R6: In compare mode, the match is taken in a cycle where the counter has just advanced to the value in the data register. At the following edge the flag sets and the output changes by the action code: 00 = hold, 01 = toggle, 10 = clear, 11 = set.
- R7: When the data register is written in the same cycle as a match, the match is judged against the old value, and the write still takes effect.
- R8: Writing 1 to a flag bit clears that flag, and writing 0 leaves it unchanged. If a flag-setting event falls in the same cycle as a clear of that flag, the flag is set.
- R9: pin_drive[n] is 0 only when ch n is in capture mode with action code 00. For ch7 and ch0, the release mask bit (bit 7 or bit 0) must also be 0. pa_release = {~pin_drive[7], ~pin_drive[0]}.
- R10: A compare-mode channel ignores its input pin. A capture-mode channel never changes its cmp_out, and never raises a flag from a counter match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Counter advance enable |
| pin_in | input | 8 | Channel input pins (asynchronous) |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for addr (combinational) |
| cmp_out | output | 8 | Compare output levels |
| pin_drive | output | 8 | Channel owns its pin |
| flag | output | 8 | Channel event flags |
| pa_release | output | 2 | {ch7, ch0} pin free for the pulse accumulator |

## Verification
The bench builds the block with its default 16-bit counter. At that width the full wrap from 0xFFFF back to zero is reachable by ticking through the whole range. Holding tick low during capture tests keeps the counter fixed, so every captured value and the three-edge synchronizer delay are known exactly. Same-cycle races are driven on purpose: a data write during a match, and a flag clear on the capture edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NCH = 8;

  localparam int A_EDG_HI = 0;
  localparam int A_EDG_LO = 1;
  localparam int A_ACT_HI = 2;
  localparam int A_ACT_LO = 3;
  localparam int A_MODE   = 4;
  localparam int A_FLAG   = 5;
  localparam int A_MASK   = 6;
  localparam int A_CNT    = 7;

  typedef enum logic [1:0] {
    EDG_OFF  = 2'b00,
    EDG_RISE = 2'b01,
    EDG_FALL = 2'b10,
    EDG_ANY  = 2'b11
  } edge_sel_e;

  typedef enum logic [1:0] {
    ACT_HOLD   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_CLEAR  = 2'b10,
    ACT_SET    = 2'b11
  } out_act_e;

  // Low bit of the code enables rising edges, high bit enables falling edges.
  function automatic logic edge_hit(input logic [1:0] code, input logic rise, input logic fall);
    return (code[0] & rise) | (code[1] & fall);
  endfunction

  function automatic logic act_level(input logic [1:0] code, input logic cur);
    logic nxt;
    case (out_act_e'(code))
      ACT_TOGGLE: nxt = ~cur;
      ACT_CLEAR:  nxt = 1'b0;
      ACT_SET:    nxt = 1'b1;
      default:    nxt = cur;
    endcase
    return nxt;
  endfunction

  function automatic logic pin_released(input logic cap_mode, input logic [1:0] code,
                                        input logic masked);
    return cap_mode && (code == 2'b00) && !masked;
  endfunction
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  output logic [CW-1:0] cnt,
  output logic          adv
);
  function automatic logic [CW-1:0] next_count(input logic [CW-1:0] c);
    return c + {{(CW-1){1'b0}}, 1'b1};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      adv <= 1'b0;
    end else begin
      adv <= tick;
      if (tick) cnt <= next_count(cnt);
    end
  end
endmodule

// File: rtl/tmr_edge_det.sv
module tmr_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic sync1, sync2, prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1 <= 1'b0;
      sync2 <= 1'b0;
      prev  <= 1'b0;
    end else begin
      sync1 <= pin;
      sync2 <= sync1;
      prev  <= sync2;
    end
  end

  assign rise = sync2 & ~prev;
  assign fall = ~sync2 & prev;
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt,
  input  logic          cnt_adv,
  input  logic          pin,
  input  logic          cap_mode,
  input  logic [1:0]    edg_code,
  input  logic [1:0]    act_code,
  input  logic          data_we,
  input  logic [CW-1:0] data_wd,
  input  logic          flag_clr,
  output logic [CW-1:0] data_q,
  output logic          flag_q,
  output logic          out_q,
  output logic          cap_evt,
  output logic          match_evt
);
  logic rise, fall;

  tmr_edge_det i_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  (pin),
    .rise (rise),
    .fall (fall)
  );

  assign cap_evt   = cap_mode & edge_hit(edg_code, rise, fall);
  // The match uses the stored value, so a write in the same cycle does not affect it.
  assign match_evt = ~cap_mode & cnt_adv & (cnt == data_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
      flag_q <= 1'b0;
      out_q  <= 1'b0;
    end else begin
      if (cap_evt)      data_q <= cnt;
      else if (data_we) data_q <= data_wd;

      if (cap_evt || match_evt) flag_q <= 1'b1;
      else if (flag_clr)        flag_q <= 1'b0;

      if (match_evt) out_q <= act_level(act_code, out_q);
    end
  end
endmodule

// File: rtl/tmr_chan_bank.sv
module tmr_chan_bank
  import tmr_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [7:0]    pin_in,
  input  logic          wr_en,
  input  logic [3:0]    addr,
  input  logic [CW-1:0] wr_data,
  output logic [CW-1:0] rd_data,
  output logic [7:0]    cmp_out,
  output logic [7:0]    pin_drive,
  output logic [7:0]    flag,
  output logic [1:0]    pa_release
);
  localparam int DSEL = $clog2(NCH);
  localparam int AW   = DSEL + 1;
  localparam int CV   = 2 * NCH;

  logic [CW-1:0]           cnt_q;
  logic                    cnt_adv;
  logic [CV-1:0]           edg_q;
  logic [CV-1:0]           act_q;
  logic [NCH-1:0]          mode_q;
  logic                    mask_hi_q, mask_lo_q;
  logic [NCH-1:0][CW-1:0]  data_all;
  logic [NCH-1:0]          cap_evt, match_evt;

  function automatic logic hit(input logic [AW-1:0] a, input int target);
    return wr_en && !a[AW-1] && (a[DSEL-1:0] == DSEL'(target));
  endfunction

  tmr_counter #(.CW(CW)) i_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick),
    .cnt  (cnt_q),
    .adv  (cnt_adv)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      edg_q     <= '0;
      act_q     <= '0;
      mode_q    <= '0;
      mask_hi_q <= 1'b0;
      mask_lo_q <= 1'b0;
    end else begin
      if (hit(addr, A_EDG_HI)) edg_q[CV-1:NCH] <= wr_data[NCH-1:0];
      if (hit(addr, A_EDG_LO)) edg_q[NCH-1:0]  <= wr_data[NCH-1:0];
      if (hit(addr, A_ACT_HI)) act_q[CV-1:NCH] <= wr_data[NCH-1:0];
      if (hit(addr, A_ACT_LO)) act_q[NCH-1:0]  <= wr_data[NCH-1:0];
      if (hit(addr, A_MODE))   mode_q          <= wr_data[NCH-1:0];
      if (hit(addr, A_MASK)) begin
        mask_hi_q <= wr_data[NCH-1];
        mask_lo_q <= wr_data[0];
      end
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic masked;
    if (i == 0) begin : g_lo
      assign masked = mask_lo_q;
    end else if (i == NCH - 1) begin : g_hi
      assign masked = mask_hi_q;
    end else begin : g_none
      assign masked = 1'b0;
    end

    tmr_channel #(.CW(CW)) i_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .cnt      (cnt_q),
      .cnt_adv  (cnt_adv),
      .pin      (pin_in[i]),
      .cap_mode (mode_q[i]),
      .edg_code (edg_q[2*i+1 -: 2]),
      .act_code (act_q[2*i+1 -: 2]),
      .data_we  (wr_en && addr[AW-1] && (addr[DSEL-1:0] == DSEL'(i))),
      .data_wd  (wr_data),
      .flag_clr (hit(addr, A_FLAG) && wr_data[i]),
      .data_q   (data_all[i]),
      .flag_q   (flag[i]),
      .out_q    (cmp_out[i]),
      .cap_evt  (cap_evt[i]),
      .match_evt(match_evt[i])
    );

    assign pin_drive[i] = ~pin_released(mode_q[i], act_q[2*i+1 -: 2], masked);
  end

  assign pa_release = {~pin_drive[NCH-1], ~pin_drive[0]};

  always_comb begin
    rd_data = '0;
    if (addr[AW-1]) begin
      rd_data = data_all[addr[DSEL-1:0]];
    end else begin
      case (int'(addr[DSEL-1:0]))
        A_EDG_HI: rd_data = CW'(edg_q[CV-1:NCH]);
        A_EDG_LO: rd_data = CW'(edg_q[NCH-1:0]);
        A_ACT_HI: rd_data = CW'(act_q[CV-1:NCH]);
        A_ACT_LO: rd_data = CW'(act_q[NCH-1:0]);
        A_MODE:   rd_data = CW'(mode_q);
        A_FLAG:   rd_data = CW'(flag);
        A_MASK:   rd_data = CW'({mask_hi_q, {(NCH-2){1'b0}}, mask_lo_q});
        default:  rd_data = cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/tmr_chan_bank_chk.sv
module tmr_chan_bank_chk
  import tmr_pkg::*;
#(
  parameter int CW = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   tick,
  input logic [CW-1:0]          cnt_q,
  input logic [2*NCH-1:0]       act_q,
  input logic [NCH-1:0]         mode_q,
  input logic [NCH-1:0][CW-1:0] data_all,
  input logic [NCH-1:0]         cap_evt,
  input logic [NCH-1:0]         match_evt,
  input logic [7:0]             flag,
  input logic [7:0]             cmp_out
);
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> cnt_q == $past(cnt_q) + CW'(1));  // R2
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));  // R2

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    AST_CAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt[i] |=> (data_all[i] == $past(cnt_q)) && flag[i]);  // R4
    AST_MATCH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      match_evt[i] |=> flag[i]);  // R6
    AST_MATCH_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (match_evt[i] && act_q[2*i+1 -: 2] == 2'b01) |=> cmp_out[i] != $past(cmp_out[i]));  // R6
    AST_CAP_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q[i] |=> $stable(cmp_out[i]));  // R10
  end
endmodule

bind tmr_chan_bank tmr_chan_bank_chk #(.CW(CW)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick),
  .cnt_q    (cnt_q),
  .act_q    (act_q),
  .mode_q   (mode_q),
  .data_all (data_all),
  .cap_evt  (cap_evt),
  .match_evt(match_evt),
  .flag     (flag),
  .cmp_out  (cmp_out)
);

// File: tb/test_tmr_chan_bank.sv
module test_tmr_chan_bank;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic [7:0]    pin_in = '0;
  logic          wr_en = 1'b0;
  logic [3:0]    addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic [CW-1:0] rd_data;
  logic [7:0]    cmp_out, pin_drive, flag;
  logic [1:0]    pa_release;

  int n_checks = 0;
  int n_err = 0;
  bit done = 1'b0;

  tmr_chan_bank #(.CW(CW)) i_tmr_chan_bank (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pin_in(pin_in), .wr_en(wr_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .cmp_out(cmp_out),
    .pin_drive(pin_drive), .flag(flag), .pa_release(pa_release)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [CW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [CW-1:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rd_data;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(posedge clk);
    #1 tick = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    logic [CW-1:0] v;
    check("R1 flag", flag, 8'h00);
    check("R1 cmp_out", cmp_out, 8'h00);
    check("R1 pin_drive", pin_drive, 8'hFF);
    check("R1 pa_release", pa_release, 2'b00);
    rd(4'd7, v);  check("R1 counter", v, 0);
    rd(4'd4, v);  check("R1 mode", v, 0);
    rd(4'd12, v); check("R1 data4", v, 0);
  endtask

  task automatic t_regs;
    logic [CW-1:0] v;
    wr(4'd0, 16'h005A); rd(4'd0, v); check("R3 edge hi readback", v, 16'h005A);
    wr(4'd3, 16'h00A5); rd(4'd3, v); check("R3 action lo readback", v, 16'h00A5);
    wr(4'd6, 16'h00FF); rd(4'd6, v); check("R3 mask bits 7,0 only", v, 16'h0081);
    wr(4'd7, 16'h1234); rd(4'd7, v); check("R3 counter write ignored", v, 0);
    wr(4'd0, 0); wr(4'd3, 0); wr(4'd6, 0);
  endtask

  task automatic t_compare;
    wr(4'd3, 16'h00C4);           // ch1 toggle, ch3 set
    wr(4'd9, 16'd5); wr(4'd11, 16'd5); wr(4'd12, 16'd5);
    ticks(5);
    check("R6 flag not before next edge", flag[1], 1'b0);
    wait_cyc(1);
    check("R6 flags ch1,3,4", flag, 8'h1A);
    check("R6 toggle/set/hold levels", cmp_out, 8'h0A);
    check("R9 compare ch with action 00 drives", pin_drive[4], 1'b1);
    wr(4'd3, 16'h0084);           // ch1 toggle, ch3 clear
    wr(4'd9, 16'd8); wr(4'd11, 16'd8);
    wr(4'd5, 16'h00FF);
    ticks(3);
    wait_cyc(1);
    check("R6 toggle back and clear", cmp_out, 8'h00);
    check("R6 only matching flags", flag, 8'h0A);
  endtask

  task automatic t_same_cycle;
    logic [CW-1:0] v;
    wr(4'd3, 16'h00B4);           // ch2 set
    wr(4'd10, 16'd9);
    wr(4'd5, 16'h00FF);
    ticks(1);
    wr(4'd10, 16'h1234);          // lands in the match cycle
    check("R7 match on old value flag", flag[2], 1'b1);
    check("R7 match on old value out", cmp_out[2], 1'b1);
    rd(4'd10, v); check("R7 write still applied", v, 16'h1234);
  endtask

  task automatic t_capture;
    logic [CW-1:0] k, v;
    wr(4'd4, 16'h00E0);           // ch5..7 capture
    wr(4'd0, 16'h0034);           // ch5 rise, ch6 any, ch7 off
    wr(4'd5, 16'h00FF);
    rd(4'd7, k);
    @(negedge clk) pin_in[7:5] = 3'b111;
    wait_cyc(2);
    check("R5 no capture before third edge", flag[5], 1'b0);
    wait_cyc(1);
    check("R5 capture at third edge", flag[5], 1'b1);
    check("R4 any-edge rising", flag[6], 1'b1);
    check("R4 code 00 disabled", flag[7], 1'b0);
    rd(4'd13, v); check("R4 ch5 captured count", v, k);
    ticks(4);
    wr(4'd5, 16'h00FF);
    @(negedge clk) pin_in[7:5] = 3'b000;
    wait_cyc(4);
    check("R4 rising-only ignores fall", flag[5], 1'b0);
    check("R4 any-edge falling", flag[6], 1'b1);
    rd(4'd14, v); check("R4 ch6 captured count", v, k + 16'd4);
    rd(4'd13, v); check("R4 ch5 data unchanged", v, k);
    wr(4'd0, 16'h0038);           // ch5 fall only
    wr(4'd5, 16'h00FF);
    @(negedge clk) pin_in[5] = 1'b1;
    wait_cyc(4);
    check("R4 falling-only ignores rise", flag[5], 1'b0);
    ticks(1);
    @(negedge clk) pin_in[5] = 1'b0;
    wait_cyc(4);
    check("R4 falling-only capture", flag[5], 1'b1);
    rd(4'd13, v); check("R4 ch5 fall count", v, k + 16'd5);
  endtask

  task automatic t_ignore;
    logic [CW-1:0] k, v;
    wr(4'd5, 16'h00FF);
    @(negedge clk) pin_in[1] = 1'b1;
    wait_cyc(4);
    @(negedge clk) pin_in[1] = 1'b0;
    wait_cyc(4);
    check("R10 compare ch ignores pin", flag[1], 1'b0);
    rd(4'd9, v); check("R10 compare data untouched", v, 16'd8);
    rd(4'd7, k);
    wr(4'd2, 16'h000C);           // ch5 action set, still capture
    wr(4'd13, k + 16'd1);
    wr(4'd5, 16'h00FF);
    ticks(1);
    wait_cyc(1);
    check("R10 capture ch output holds", cmp_out[5], 1'b0);
    check("R10 capture ch no match flag", flag[5], 1'b0);
  endtask

  task automatic t_flags;
    wr(4'd5, 16'h00FF);
    @(negedge clk) pin_in[6] = 1'b1;
    wait_cyc(2);
    wr_en = 1'b1; addr = 4'd5; wr_data = 16'h0040;
    @(posedge clk);
    #1 wr_en = 1'b0;
    check("R8 set wins over clear", flag[6], 1'b1);
    wr(4'd5, 16'h00BF);
    check("R8 zero bit no effect", flag[6], 1'b1);
    wr(4'd5, 16'h0040);
    check("R8 write one clears", flag[6], 1'b0);
  endtask

  task automatic t_release;
    check("R9 ch7 released", {pin_drive[7], pa_release[1]}, 2'b01);
    check("R9 ch5 action keeps pin", pin_drive[5], 1'b1);
    wr(4'd6, 16'h0080);
    check("R9 ch7 mask holds pin", {pin_drive[7], pa_release[1]}, 2'b10);
    check("R9 ch0 compare drives", {pin_drive[0], pa_release[0]}, 2'b10);
    wr(4'd4, 16'h00E1);
    check("R9 ch0 released", {pin_drive[0], pa_release[0]}, 2'b01);
    wr(4'd6, 16'h0081);
    check("R9 ch0 mask holds pin", pa_release, 2'b00);
  endtask

  task automatic t_wrap;
    logic [CW-1:0] v, w;
    rd(4'd7, v);
    wait_cyc(3);
    rd(4'd7, w); check("R2 holds without tick", w, v);
    ticks(3);
    rd(4'd7, w); check("R2 steps per tick", w, v + 16'd3);
    ticks(int'(16'hFFFF - w));
    rd(4'd7, v); check("R2 reaches max", v, 16'hFFFF);
    ticks(1);
    rd(4'd7, v); check("R2 wraps to zero", v, 16'h0000);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset;
    t_regs;
    t_compare;
    t_same_cycle;
    t_capture;
    t_ignore;
    t_flags;
    t_release;
    t_wrap;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_err++;
      $display("FAIL watchdog got=timeout exp=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end
endmodule